// File: doc/BRIEF.md
# Buffered SPI Flash Command Engine

This block is an SPI master that runs one flash transaction per start request. Before the start, the caller loads up to eight command bytes into a command buffer, one byte per write, and programs a transfer length in bytes. On start, the engine pulls chip select low. It then shifts out that many bytes, most significant bit first, beginning with the opcode in slot 0. A slot that was not loaded since the previous transaction goes out as a dummy byte of 0x00.

The engine drives dummy bytes so that data can be read back. Each byte that arrives on the serial input after the opcode byte is stored in a response buffer, in the order it arrives. A transaction of length N therefore leaves N-1 valid response bytes. When the programmed length is used up, the engine releases chip select. It then waits out a guard gap with chip select high, pulses done, and drops busy. The serial clock is a parameterised divide of the system clock and uses mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: Chip select goes low only one cycle after an accepted start. It is low before the first serial clock rise and returns high only after the last programmed byte has been shifted. While busy is low, chip select is high.
- R2: Bytes go out in buffer slot order 0, 1, 2, and so on. Each byte is sent most significant bit first. The byte in slot 0 is the opcode.
- R3: A length of N (1 to 8) produces exactly 8*N serial clock rising edges. With length 1 the response count is 0.
- R4: A slot not written since the last completed transaction is sent as 0x00. Completing a transaction marks every command slot as unloaded.
- R5: The byte received during transmitted byte k (k at least 1) is stored at response address k-1. It is assembled MSB first from samples taken on rising serial clock edges. At done, the response count equals the length minus one.
- R6: The serial clock idles low. The serial output changes only while the serial clock is low, never during a high phase.
- R7: A start request, a command buffer write or a length write that arrives while busy is high has no effect.
- R8: Done is high for exactly one cycle. Busy is low in the cycle that done is high.
- R9: A start with length 0 never asserts chip select. Done is high in the cycle after the start and busy stays low.
- R10: Between two transactions, chip select stays high for at least 2*HALF_DIV system clock cycles, which is one full serial clock period.
- R11: A length write above 8 is stored as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command buffer write strobe |
| cmd_addr_i | input | 3 | Command buffer slot |
| cmd_data_i | input | 8 | Command byte to store |
| len_we_i | input | 1 | Length register write strobe |
| len_i | input | 4 | Transfer length in bytes |
| start_i | input | 1 | Start request, one cycle |
| rsp_addr_i | input | 3 | Response buffer read address |
| rsp_data_o | output | 8 | Response byte at rsp_addr_i |
| rsp_count_o | output | 4 | Valid response bytes from the last transaction |
| busy_o | output | 1 | Transaction or guard gap in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is a buffer write arriving in the middle of a transaction, aimed at a slot that has not yet been shifted out. If the write were wrongly accepted, the changed byte would still appear on the wire. To reach this case, the bench starts a five-byte transfer and waits a few cycles into the opcode byte. It then writes a new value to slot 3, writes length 1, and issues a second start. It checks that the original five bytes, and only 40 clocks, appear on the wire. A follow-up transfer with no fresh loads then shows that the length was not changed and that all slots went out as dummies.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_cmd_bufs.sv
module spi_cmd_bufs #(
  parameter int BUF_BYTES = 8,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             cmd_we_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             consume_i,
  input  logic [LEN_W-1:0] fetch_idx_i,
  output logic [7:0]       fetch_data_o,
  input  logic             rsp_we_i,
  input  logic [AW-1:0]    rsp_waddr_i,
  input  logic [7:0]       rsp_wdata_i,
  input  logic [AW-1:0]    rsp_raddr_i,
  output logic [7:0]       rsp_rdata_o
);
  logic [7:0]           cmd_mem [BUF_BYTES];
  logic [BUF_BYTES-1:0] cmd_vld;
  logic [7:0]           rsp_mem [BUF_BYTES];

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = cmd_we_i && !busy_i && (cmd_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_mem[g] <= 8'h00;
        cmd_vld[g] <= 1'b0;
      end else if (hit) begin
        cmd_mem[g] <= cmd_data_i;
        cmd_vld[g] <= 1'b1;
      end else if (consume_i) begin
        cmd_vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   rsp_mem[g] <= 8'h00;
      else if (rsp_we_i && rsp_waddr_i == AW'(g))    rsp_mem[g] <= rsp_wdata_i;
    end
  end

  // unloaded or out-of-range slots go out as dummies
  always_comb begin
    fetch_data_o = 8'h00;
    if (fetch_idx_i < LEN_W'(BUF_BYTES)) begin
      if (cmd_vld[fetch_idx_i[AW-1:0]]) fetch_data_o = cmd_mem[fetch_idx_i[AW-1:0]];
    end
  end

  assign rsp_rdata_o = rsp_mem[rsp_raddr_i];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             tick_en_o,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] fetch_idx_o,
  input  logic [7:0]       fetch_data_i,
  output logic             consume_o,
  output logic             rsp_we_o,
  output logic [AW-1:0]    rsp_waddr_o,
  output logic [7:0]       rsp_wdata_o,
  output logic [LEN_W-1:0] rsp_count_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  eng_state_e       state_q;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] byte_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       tx_q;
  logic [6:0]       rx_q;
  logic [AW-1:0]    rptr_q;
  logic [LEN_W-1:0] rcnt_q;
  logic             gap_q;
  logic             cs_n_q;
  logic             sclk_q;
  logic             done_q;
  logic             rise;
  logic             last_bit;
  logic             last_byte;

  assign tick_en_o   = (state_q != ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign cs_n_o      = cs_n_q;
  assign sclk_o      = sclk_q;
  assign mosi_o      = cs_n_q ? 1'b0 : tx_q[7];
  assign rsp_count_o = rcnt_q;

  assign fetch_idx_o = (state_q == ST_IDLE) ? '0 : byte_q + LEN_W'(1);
  assign last_bit    = (bit_q == 3'd7);
  assign last_byte   = (byte_q == len_q - LEN_W'(1));
  assign rise        = tick_i && (state_q == ST_SETUP || state_q == ST_LOW);

  // capture only after the opcode byte
  assign rsp_we_o    = rise && last_bit && (byte_q != '0);
  assign rsp_waddr_o = rptr_q;
  assign rsp_wdata_o = {rx_q, miso_i};
  assign consume_o   = tick_i && (state_q == ST_GAP) && gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      len_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rptr_q  <= '0;
      rcnt_q  <= '0;
      gap_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
              rcnt_q <= '0;
            end else begin
              state_q <= ST_SETUP;
              cs_n_q  <= 1'b0;
              len_q   <= len_i;
              byte_q  <= '0;
              bit_q   <= '0;
              rptr_q  <= '0;
              tx_q    <= fetch_data_i;
            end
          end
        end
        ST_SETUP, ST_LOW: begin
          if (tick_i) begin
            sclk_q  <= 1'b1;
            rx_q    <= {rx_q[5:0], miso_i};
            state_q <= ST_HIGH;
            if (rsp_we_o) rptr_q <= rptr_q + AW'(1);
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            sclk_q <= 1'b0;
            if (last_bit && last_byte) begin
              state_q <= ST_HOLD;
            end else if (last_bit) begin
              byte_q  <= byte_q + LEN_W'(1);
              bit_q   <= '0;
              tx_q    <= fetch_data_i;
              state_q <= ST_LOW;
            end else begin
              bit_q   <= bit_q + 3'd1;
              tx_q    <= {tx_q[6:0], 1'b0};
              state_q <= ST_LOW;
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            cs_n_q  <= 1'b1;
            gap_q   <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (gap_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              rcnt_q  <= len_q - LEN_W'(1);
            end else begin
              gap_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int BUF_BYTES = 8,
  parameter int HALF_DIV  = 2,
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             start_i,
  input  logic [AW-1:0]    rsp_addr_i,
  output logic [7:0]       rsp_data_o,
  output logic [LEN_W-1:0] rsp_count_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic [LEN_W-1:0] len_q;
  logic             tick;
  logic             tick_en;
  logic [LEN_W-1:0] fetch_idx;
  logic [7:0]       fetch_data;
  logic             consume;
  logic             rsp_we;
  logic [AW-1:0]    rsp_waddr;
  logic [7:0]       rsp_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (len_we_i && !busy_o)
      len_q <= (len_i > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : len_i;
  end

  spi_cmd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .tick_o (tick)
  );

  spi_cmd_bufs #(.BUF_BYTES(BUF_BYTES), .AW(AW), .LEN_W(LEN_W)) u_bufs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_o),
    .cmd_we_i     (cmd_we_i),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_data_i   (cmd_data_i),
    .consume_i    (consume),
    .fetch_idx_i  (fetch_idx),
    .fetch_data_o (fetch_data),
    .rsp_we_i     (rsp_we),
    .rsp_waddr_i  (rsp_waddr),
    .rsp_wdata_i  (rsp_wdata),
    .rsp_raddr_i  (rsp_addr_i),
    .rsp_rdata_o  (rsp_data_o)
  );

  spi_cmd_ctrl #(.BUF_BYTES(BUF_BYTES), .AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .tick_en_o    (tick_en),
    .start_i      (start_i),
    .len_i        (len_q),
    .fetch_idx_o  (fetch_idx),
    .fetch_data_i (fetch_data),
    .consume_o    (consume),
    .rsp_we_o     (rsp_we),
    .rsp_waddr_o  (rsp_waddr),
    .rsp_wdata_o  (rsp_wdata),
    .rsp_count_o  (rsp_count_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cs_n_o       (cs_n_o),
    .sclk_o       (sclk_o),
    .mosi_o       (mosi_o),
    .miso_i       (miso_i)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_q,
  input logic             busy_o,
  input logic             done_o,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             mosi_o
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt <= 16'hFFFF;
    else if (!cs_n_o)            hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  p_cs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);

  p_cs_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(start_i && !busy_o));

  p_sclk_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  p_mosi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_len_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_q == '0) |=> (done_o && cs_n_o && !busy_o));

  p_cs_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (32'(hi_cnt) >= 2 * HALF_DIV));

  p_len_clamp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(len_q) <= 8);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .len_q   (len_q),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .mosi_o  (mosi_o)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  localparam int HD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       len_we = 1'b0;
  logic [3:0] len = '0;
  logic       start = 1'b0;
  logic [2:0] rsp_addr = '0;
  logic [7:0] rsp_data;
  logic [3:0] rsp_count;
  logic       busy, done, cs_n, sclk, mosi, miso;

  int total = 0;
  int bad = 0;
  logic [63:0] slv_pat = '0;
  int slv_idx = 0;
  logic [63:0] mon_bits = '0;
  int mon_clks = 0;
  int cs_falls = 0;
  int hi_run = 0;
  int last_gap = 0;
  int mode_err = 0;
  logic sclk_d = 1'b0, mosi_d = 1'b0, cs_d = 1'b1;

  always #4 clk = ~clk;

  spi_cmd_engine #(.BUF_BYTES(8), .HALF_DIV(HD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .len_we_i(len_we), .len_i(len), .start_i(start),
    .rsp_addr_i(rsp_addr), .rsp_data_o(rsp_data), .rsp_count_o(rsp_count),
    .busy_o(busy), .done_o(done), .cs_n_o(cs_n), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  // slave: first bit ready at chip select fall, advance on falling clock
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) slv_idx <= 0;
    else      slv_idx <= slv_idx + 1;
  end
  assign miso = (slv_idx < 64) ? slv_pat[63 - slv_idx] : 1'b0;

  always @(posedge sclk) begin
    mon_bits <= {mon_bits[62:0], mosi};
    mon_clks <= mon_clks + 1;
  end

  always @(posedge clk) begin
    if (cs_d && !cs_n) begin
      cs_falls <= cs_falls + 1;
      last_gap <= hi_run;
    end
    hi_run <= cs_n ? hi_run + 1 : 0;
    if (sclk && sclk_d && mosi != mosi_d) mode_err <= mode_err + 1;
    if (cs_n && sclk) mode_err <= mode_err + 1;
    sclk_d <= sclk; mosi_d <= mosi; cs_d <= cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input int a, input logic [7:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_addr = 3'(a); cmd_data = d;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_len(input logic [3:0] l);
    @(negedge clk); len_we = 1'b1; len = l;
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, req, 64'(done), 64'd1);
    chk(!busy, "R8 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic rd_rsp(input int a, output logic [7:0] d);
    @(negedge clk); rsp_addr = 3'(a);
    #1 d = rsp_data;
  endtask

  task automatic t_reset();
    chk(cs_n && !sclk && !busy && !done, "R1 reset idle", {cs_n, sclk, busy, done}, 64'h8);
    chk(rsp_count == 0, "R5 reset count", 64'(rsp_count), 64'd0);
  endtask

  task automatic t_cmd_only();
    int c0;
    wr_cmd(0, 8'h06); wr_len(4'd1);
    c0 = mon_clks;
    pulse_start(); wait_done("R3 cmd only done");
    chk(mon_clks - c0 == 8, "R3 cmd only clocks", 64'(mon_clks - c0), 64'd8);
    chk(mon_bits[7:0] == 8'h06, "R2 cmd only byte", 64'(mon_bits[7:0]), 64'h06);
    chk(rsp_count == 0, "R3 cmd only count", 64'(rsp_count), 64'd0);
  endtask

  task automatic t_program();
    int c0;
    wr_cmd(0, 8'h02); wr_cmd(1, 8'h12); wr_cmd(2, 8'h34); wr_cmd(3, 8'h56); wr_cmd(4, 8'hA5);
    wr_len(4'd5);
    c0 = mon_clks;
    pulse_start(); wait_done("R1 program done");
    chk(mon_clks - c0 == 40, "R3 program clocks", 64'(mon_clks - c0), 64'd40);
    chk(mon_bits[39:0] == 40'h02123456A5, "R2 program order", 64'(mon_bits[39:0]), 64'h02123456A5);
    chk(rsp_count == 4, "R5 program count", 64'(rsp_count), 64'd4);
  endtask

  task automatic t_id_read();
    logic [7:0] b;
    slv_pat = 64'h00BF258E_00000000;
    wr_cmd(0, 8'h9F); wr_len(4'd4);
    pulse_start(); wait_done("R5 id done");
    chk(mon_bits[31:0] == 32'h9F000000, "R4 id dummies", 64'(mon_bits[31:0]), 64'h9F000000);
    chk(rsp_count == 3, "R5 id count", 64'(rsp_count), 64'd3);
    rd_rsp(0, b); chk(b == 8'hBF, "R5 rsp0", 64'(b), 64'hBF);
    rd_rsp(1, b); chk(b == 8'h25, "R5 rsp1", 64'(b), 64'h25);
    rd_rsp(2, b); chk(b == 8'h8E, "R5 rsp2", 64'(b), 64'h8E);
  endtask

  task automatic t_consume();
    wr_len(4'd2);
    pulse_start(); wait_done("R4 consume done");
    chk(mon_bits[15:0] == 16'h0000, "R4 slots cleared", 64'(mon_bits[15:0]), 64'h0);
  endtask

  task automatic t_busy_ignore();
    int c0;
    for (int i = 0; i < 5; i++) wr_cmd(i, 8'(i + 1));
    wr_len(4'd5);
    c0 = mon_clks;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(busy, "R7 busy during txn", 64'(busy), 64'd1);
    wr_cmd(3, 8'hEE); wr_len(4'd1); pulse_start();
    wait_done("R7 busy txn done");
    chk(mon_clks - c0 == 40, "R7 start ignored clocks", 64'(mon_clks - c0), 64'd40);
    chk(mon_bits[39:0] == 40'h0102030405, "R7 write ignored", 64'(mon_bits[39:0]), 64'h0102030405);
    c0 = mon_clks;
    pulse_start(); wait_done("R7 follow done");
    chk(mon_clks - c0 == 40, "R7 length write ignored", 64'(mon_clks - c0), 64'd40);
    chk(mon_bits[39:0] == 40'h0, "R4 follow dummies", 64'(mon_bits[39:0]), 64'h0);
  endtask

  task automatic t_len_zero();
    int f0;
    wr_len(4'd0);
    f0 = cs_falls;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && !busy, "R9 immediate done", {done, busy}, 64'h2);
    @(negedge clk);
    chk(!done, "R8 zero done pulse", 64'(done), 64'd0);
    repeat (10) @(negedge clk);
    chk(cs_falls == f0 && cs_n, "R9 cs never low", 64'(cs_falls - f0), 64'd0);
  endtask

  task automatic t_back2back();
    wr_cmd(0, 8'h05); wr_len(4'd1);
    pulse_start();
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R10 second done");
    chk(last_gap >= 2 * HD, "R10 cs gap", 64'(last_gap), 64'(2 * HD));
  endtask

  task automatic t_clamp();
    int c0;
    logic [7:0] b;
    slv_pat = 64'h0011223344556677;
    wr_len(4'd15);
    c0 = mon_clks;
    pulse_start(); wait_done("R11 clamp done");
    chk(mon_clks - c0 == 64, "R11 clamp clocks", 64'(mon_clks - c0), 64'd64);
    chk(rsp_count == 7, "R11 clamp count", 64'(rsp_count), 64'd7);
    rd_rsp(6, b); chk(b == 8'h77, "R5 rsp6", 64'(b), 64'h77);
    rd_rsp(0, b); chk(b == 8'h11, "R5 rsp0 clamp", 64'(b), 64'h11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_only();
    t_program();
    t_id_read();
    t_consume();
    t_busy_ignore();
    t_len_zero();
    t_back2back();
    t_clamp();
    chk(mode_err == 0, "R6 mosi change on high clock", 64'(mode_err), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule